// File: doc/BRIEF.md
# Expansion Bus Autoconfig Responder

This block is the identification and address-assignment front end of a plug-in expansion card. After reset the card is unplaced. It answers in a fixed configuration window selected by the top address byte. There it returns its identity bytes to the host one nibble per read. The host places the card in two writes. The first write stages the low nibble of the new base byte. The second write supplies the high nibble and moves the card to the resulting base. From then on the card answers only at that base. The host may instead tell the card to shut up, and the card then stays off the bus until the next reset.

Reads are answered one cycle after the strobe, with an acknowledge and a data byte. The nibble sits in data bits 7:4, and data bits 3:0 read zero. The card-select output follows the address bus one cycle later. It tells the rest of the card that its local map is being addressed. The local map is reachable in the configuration window before placement, and at the base after placement.

Top module: `autocfg_resp`

## Requirements
- R1: Synchronous active-high reset. After reset `cfg_done`, `base_byte`, `card_sel` and `rd_ack` are 0 and the staged nibble is 0, so a commit write issued straight after reset yields a base whose low nibble is 0.
- R2: A read answers only while the card is unplaced. The address must have bits 23:16 equal to 0xE8, bits 15:7 zero and bit 0 zero. The cycle after the strobe, `rd_ack` is 1 and `rd_data` is {nibble, 4'h0}. Any other read leaves `rd_ack` at 0 and `rd_data` at 0x00 in that cycle.
- R3: Identity byte k is read at offsets 4k (high nibble) and 4k+2 (low nibble). Byte 0 is the board type 0xD1, returned as is. It encodes second-generation board, not pooled memory, ROM vector valid, not chained, 64 KiB.
- R4: Every other identity byte is returned bit-inverted. Byte 1 is the product (0). Byte 2 is the flags (0x00: no space preference, shut-up supported). Bytes 4 and 5 are the vendor 0x1212, high byte first. Bytes 6 to 9 are the serial number 0. Bytes 10 and 11 are the ROM vector 0x1000, high byte first. Unused bytes read as inverted zero.
- R5: A write at window offset 0x4A stores data bits 3:0 as the staged nibble. A later write there overwrites it.
- R6: A write at window offset 0x48 sets `base_byte` to {data[7:4], staged nibble} and `cfg_done` to 1, both visible the cycle after the strobe.
- R7: A commit without a fresh staging write uses whatever nibble was staged last, even across intervening reads.
- R8: A write at window offset 0x4C while unplaced silences the card until reset. Reads get no acknowledge, `card_sel` stays 0, and later stage or commit writes have no effect. A reset restores normal answering.
- R9: `card_sel` is registered. It is 1 the cycle after an address whose bits 23:16 are 0xE8 while unplaced, or equal to `base_byte` once placed, and 0 otherwise.
- R10: Once placed, the card ignores the configuration window. Reads there get no acknowledge, and a further commit write leaves `base_byte` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| rd_data | output | 8 | Read data, nibble in bits 7:4 |
| rd_ack | output | 1 | Read answered, one cycle after the strobe |
| cfg_done | output | 1 | Card has been placed at its base |
| base_byte | output | 8 | Latched base address byte |
| card_sel | output | 1 | Registered local-map select |

## Verification
Two conditions are hard to reach from the ports. The first is the stale-nibble commit, because the staged nibble is never visible directly. The stimulus stages a nibble, overwrites it, issues unrelated reads and only then commits. It also commits straight after reset, so the nibble appears in `base_byte`. The second is the silenced state, because it can only be reached before placement and is left only by reset. The stimulus shuts the card up, tries every kind of access, then resets and sweeps the identity window again.

// File: rtl/autocfg_pkg.sv
package autocfg_pkg;

  typedef enum logic [1:0] {
    AC_UNPLACED = 2'd0,
    AC_PLACED   = 2'd1,
    AC_SILENT   = 2'd2
  } ac_state_e;

  typedef struct packed {
    logic hi_match;   // top address byte equals configuration window
    logic rd_id;      // identity read hit
    logic wr_stage;   // low-nibble staging write
    logic wr_commit;  // base commit write
    logic wr_shut;    // shut-up write
  } ac_dec_t;

  localparam logic [5:0] OFFW_COMMIT = 6'h24;  // byte offset 0x48
  localparam logic [5:0] OFFW_STAGE  = 6'h25;  // byte offset 0x4A
  localparam logic [5:0] OFFW_SHUT   = 6'h26;  // byte offset 0x4C

endpackage

// File: rtl/autocfg_decode.sv
module autocfg_decode
  import autocfg_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          HI_W     = 8,
  parameter int          OFF_W    = 7,
  parameter logic [7:0]  CFG_BASE = 8'hE8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output ac_dec_t           dec,
  output logic [OFF_W-2:0]  word_off
);
  localparam int MID_LO = OFF_W;
  localparam int MID_HI = ADDR_W - HI_W - 1;

  logic hit_hi, mid_zero, even, in_win;
  logic [OFF_W-1:0] off;

  always_comb begin
    off      = addr[OFF_W-1:0];
    hit_hi   = (addr[ADDR_W-1 -: HI_W] == CFG_BASE);
    mid_zero = (addr[MID_HI:MID_LO] == '0);
    even     = ~off[0];
    in_win   = hit_hi & mid_zero & even;
    word_off = off[OFF_W-1:1];

    dec.hi_match  = hit_hi;
    dec.rd_id     = rd & in_win;
    dec.wr_stage  = wr & in_win & (word_off == OFFW_STAGE);
    dec.wr_commit = wr & in_win & (word_off == OFFW_COMMIT);
    dec.wr_shut   = wr & in_win & (word_off == OFFW_SHUT);
  end
endmodule

// File: rtl/autocfg_id_rom.sv
module autocfg_id_rom #(
  parameter int         WOFF_W    = 6,
  parameter logic [15:0] VENDOR   = 16'h1212,
  parameter logic [7:0]  PRODUCT  = 8'd0,
  parameter logic [31:0] SERIAL   = 32'd0,
  parameter logic [15:0] ROM_VEC  = 16'h1000,
  parameter logic [2:0]  SIZE_CODE = 3'b001,
  parameter logic [7:0]  FLAGS    = 8'h00
) (
  input  logic [WOFF_W-1:0] word_off,
  output logic [3:0]        nibble
);
  localparam int NBYTES = 1 << (WOFF_W - 1);
  localparam int SER_N  = 4;
  localparam int SER_0  = 6;
  // second generation, not pooled, rom valid, not chained, size code
  localparam logic [7:0] TYPE_B = {2'b11, 1'b0, 1'b1, 1'b0, SIZE_CODE};

  logic [7:0] raw   [NBYTES];
  logic [7:0] shown [NBYTES];

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_byte
      if (g == 0) begin : g_type
        assign raw[g] = TYPE_B;
      end else if (g == 1) begin : g_prod
        assign raw[g] = PRODUCT;
      end else if (g == 2) begin : g_flag
        assign raw[g] = FLAGS;
      end else if (g == 4) begin : g_vhi
        assign raw[g] = VENDOR[15:8];
      end else if (g == 5) begin : g_vlo
        assign raw[g] = VENDOR[7:0];
      end else if (g >= SER_0 && g < SER_0 + SER_N) begin : g_ser
        assign raw[g] = SERIAL[8*(SER_N-1-(g-SER_0)) +: 8];
      end else if (g == 10) begin : g_rhi
        assign raw[g] = ROM_VEC[15:8];
      end else if (g == 11) begin : g_rlo
        assign raw[g] = ROM_VEC[7:0];
      end else begin : g_nil
        assign raw[g] = 8'h00;
      end
      if (g == 0) begin : g_plain
        assign shown[g] = raw[g];
      end else begin : g_inv
        assign shown[g] = ~raw[g];
      end
    end
  endgenerate

  logic [7:0] sel_b;
  always_comb begin
    sel_b  = shown[word_off[WOFF_W-1:1]];
    nibble = word_off[0] ? sel_b[3:0] : sel_b[7:4];
  end
endmodule

// File: rtl/autocfg_state.sv
module autocfg_state
  import autocfg_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  ac_dec_t         dec,
  input  logic [7:0]      wdata,
  output ac_state_e       state,
  output logic [HI_W-1:0] base
);
  localparam int NIB_W = HI_W / 2;

  logic [NIB_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= AC_UNPLACED;
      stage_q <= '0;
      base    <= '0;
    end else if (state == AC_UNPLACED) begin
      if (dec.wr_shut) begin
        state <= AC_SILENT;
      end else if (dec.wr_commit) begin
        state <= AC_PLACED;
        base  <= {wdata[7 -: NIB_W], stage_q};
      end
      if (dec.wr_stage) begin
        stage_q <= wdata[NIB_W-1:0];
      end
    end
  end
endmodule

// File: rtl/autocfg_resp.sv
module autocfg_resp
  import autocfg_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter logic [7:0]  CFG_BASE = 8'hE8,
  parameter logic [15:0] VENDOR   = 16'h1212,
  parameter logic [7:0]  PRODUCT  = 8'd0,
  parameter logic [31:0] SERIAL   = 32'd0,
  parameter logic [15:0] ROM_VEC  = 16'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [7:0]        rd_data,
  output logic              rd_ack,
  output logic              cfg_done,
  output logic [7:0]        base_byte,
  output logic              card_sel
);
  localparam int HI_W  = 8;
  localparam int OFF_W = 7;
  localparam int WOFF_W = OFF_W - 1;

  ac_dec_t          dec;
  logic [WOFF_W-1:0] word_off;
  logic [3:0]       nib;
  ac_state_e        state;
  logic [HI_W-1:0]  base_q;
  logic             silent;

  autocfg_decode #(
    .ADDR_W(ADDR_W), .HI_W(HI_W), .OFF_W(OFF_W), .CFG_BASE(CFG_BASE)
  ) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .dec(dec), .word_off(word_off)
  );

  autocfg_id_rom #(
    .WOFF_W(WOFF_W), .VENDOR(VENDOR), .PRODUCT(PRODUCT),
    .SERIAL(SERIAL), .ROM_VEC(ROM_VEC), .SIZE_CODE(3'b001), .FLAGS(8'h00)
  ) u_rom (
    .word_off(word_off), .nibble(nib)
  );

  autocfg_state #(.HI_W(HI_W)) u_st (
    .clk(clk), .rst(rst), .dec(dec), .wdata(bus_wdata),
    .state(state), .base(base_q)
  );

  logic ack_q, sel_q;
  logic [7:0] data_q;
  logic answer;

  always_comb begin
    answer = dec.rd_id && (state == AC_UNPLACED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      data_q <= 8'h00;
      sel_q  <= 1'b0;
    end else begin
      ack_q  <= answer;
      data_q <= answer ? {nib, 4'h0} : 8'h00;
      sel_q  <= ((state == AC_UNPLACED) && dec.hi_match) ||
                ((state == AC_PLACED) && (bus_addr[ADDR_W-1 -: HI_W] == base_q));
    end
  end

  assign silent    = (state == AC_SILENT);
  assign rd_ack    = ack_q;
  assign rd_data   = data_q;
  assign card_sel  = sel_q;
  assign cfg_done  = (state == AC_PLACED);
  assign base_byte = base_q;
endmodule

// File: rtl/autocfg_resp_chk.sv
module autocfg_resp_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_rd,
  input logic [7:0] addr_hi,
  input logic       cfg_done,
  input logic [7:0] base_byte,
  input logic       card_sel,
  input logic       rd_ack,
  input logic       silent
);
  AST_ACK_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> $past(bus_rd)); // R2

  AST_PLACED_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> cfg_done); // R6

  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> $stable(base_byte)); // R10

  AST_NO_ACK_PLACED: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> !rd_ack); // R10

  AST_SEL_AT_BASE: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> (card_sel == ($past(addr_hi) == base_byte))); // R9

  AST_SILENT_QUIET: assert property (@(posedge clk) disable iff (rst)
    silent |=> (!rd_ack && !card_sel && silent)); // R8

  AST_MODES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(silent && cfg_done)); // R8
endmodule

bind autocfg_resp autocfg_resp_chk u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .addr_hi(bus_addr[23:16]),
  .cfg_done(cfg_done), .base_byte(base_byte), .card_sel(card_sel),
  .rd_ack(rd_ack), .silent(silent)
);

// File: tb/autocfg_resp_tb.sv
`timescale 1ns/1ps
module autocfg_resp_tb;
  logic clk = 0;
  logic rst = 1;
  logic [23:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] rd_data, base_byte;
  logic rd_ack, cfg_done, card_sel;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  autocfg_resp u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .rd_data(rd_data), .rd_ack(rd_ack),
    .cfg_done(cfg_done), .base_byte(base_byte), .card_sel(card_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_byte(input int k);
    logic [7:0] r;
    case (k)
      0: return 8'hD1;
      1: r = 8'h00;
      2: r = 8'h00;
      4: r = 8'h12;
      5: r = 8'h12;
      10: r = 8'h10;
      11: r = 8'h00;
      default: r = 8'h00;
    endcase
    return ~r;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1; bus_rd = 0; bus_wr = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  // drive one-cycle read, sample outputs one cycle later
  task automatic rd(input logic [23:0] a, output logic ack, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; ack = rd_ack; d = rd_data;
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic sel_at(input logic [23:0] a, output logic s);
    @(negedge clk); bus_addr = a;
    @(negedge clk); s = card_sel;
  endtask

  task automatic sweep(input string tag);
    logic ack; logic [7:0] d, b, e;
    for (int off = 0; off < 128; off++) begin
      rd(24'hE80000 | 24'(off), ack, d);
      if (off[0]) begin
        check({tag, " R2 odd ack"}, ack, 0);
        check({tag, " R2 odd data"}, d, 0);
      end else begin
        b = id_byte(off >> 2);
        e = off[1] ? {b[3:0], 4'h0} : {b[7:4], 4'h0};
        check({tag, " R2 ack"}, ack, 1);
        check(off < 4 ? {tag, " R3 type"} : {tag, " R4 inverted"}, d, e);
      end
    end
  endtask

  initial begin
    logic ack, s; logic [7:0] d;
    fork
      begin
        do_reset();
        // R1 reset state
        check("R1 cfg_done", cfg_done, 0);
        check("R1 base", base_byte, 0);
        check("R1 card_sel", card_sel, 0);
        check("R1 rd_ack", rd_ack, 0);

        sweep("pre");
        // R2 decode misses
        rd(24'hE80100, ack, d); check("R2 mid bits", ack, 0);
        rd(24'hE90000, ack, d); check("R2 other window", ack, 0);
        check("R2 miss data", d, 0);
        // R9 select before placement
        sel_at(24'hE81234, s); check("R9 window sel", s, 1);
        sel_at(24'h470000, s); check("R9 off sel", s, 0);

        // R5 stage and overwrite, R6 commit, R7 stale with reads between
        wr(24'hE8004A, 8'hA3);
        wr(24'hE8004A, 8'h57);
        rd(24'hE80000, ack, d); rd(24'hE80010, ack, d);
        check("R6 not yet", cfg_done, 0);
        wr(24'hE80048, 8'h4F);
        check("R6 cfg_done", cfg_done, 1);
        check("R5 R7 base", base_byte, 8'h47);
        // R10 window ignored after placement
        rd(24'hE80000, ack, d); check("R10 no ack", ack, 0);
        wr(24'hE8004A, 8'h01);
        wr(24'hE80048, 8'h90); check("R10 base kept", base_byte, 8'h47);
        // R9 select after placement
        sel_at(24'h47ABCD, s); check("R9 base sel", s, 1);
        sel_at(24'hE80000, s); check("R9 old window", s, 0);
        sel_at(24'h480000, s); check("R9 neighbour", s, 0);
        for (int h = 0; h < 256; h++) begin
          sel_at({8'(h), 16'h0}, s);
          check("R9 sweep", s, (h == 8'h47) ? 1 : 0);
        end

        // R1 R7 staged nibble cleared by reset
        do_reset();
        check("R1 after reset", cfg_done, 0);
        wr(24'hE80048, 8'h2C);
        check("R1 R7 zero nibble", base_byte, 8'h20);

        // R8 shut-up
        do_reset();
        wr(24'hE8004C, 8'h00);
        rd(24'hE80000, ack, d); check("R8 no ack", ack, 0);
        check("R8 no data", d, 0);
        sel_at(24'hE80000, s); check("R8 no sel", s, 0);
        wr(24'hE8004A, 8'h05);
        wr(24'hE80048, 8'h60);
        check("R8 not placed", cfg_done, 0);
        check("R8 base kept", base_byte, 0);
        sel_at(24'h650000, s); check("R8 no sel base", s, 0);
        do_reset();
        sweep("post");
        // R5 stage from data low nibble after reset
        wr(24'hE8004A, 8'hF9);
        wr(24'hE80048, 8'hB0);
        check("R5 R6 base", base_byte, 8'hB9);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule